// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

An eight-pin general-purpose I/O port controlled through a small memory-mapped register bus that spans a 4 KB window. Software sets each pin as input or output and reaches the port data through a window of 256 word addresses. Address bits 9 down to 2 act as a bit mask, so any subset of pins can be read or changed in one access, with no read-modify-write. Each pin can raise an interrupt on a level, on one edge, or on both edges. The interrupts have a mask, a sticky raw status and write-one-to-clear. The port also holds plain pad-configuration bytes, a key-protected commit mask that limits which alternate-function bits can change, and read-only identification bytes at the top of the map.

Requests arrive on a valid/ready channel. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. A write takes effect on that edge and returns no response. A read loads its result into a single response register, which shows `rsp_valid` from the next cycle. The response holds, with stable data, until `rsp_ready` is high. `req_ready` is low only while a response is pending and `rsp_ready` is low, so back-pressure on the response channel stalls the request channel. A requester must keep the request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `amgpio_port`

## Requirements
- R1: After reset: the lock word reads 1, the commit mask reads 0xFF, and every other register reads 0. `pin_out` is 0xFF and `irq` is low.
- R2: An access at a byte offset below 0x400 reaches the data register and uses offset bits [9:2] as an 8-bit mask. A read returns the data ANDed with the mask. A write changes only the bits set in both the mask and the direction register (offset 0x400, 1 = output).
- R3: Data bits whose direction bit is 0 follow `pin_in` through a two-flop synchroniser. A data write has no effect on them.
- R4: `pin_out[i]` equals data bit i when direction bit i is 1, and is 1 when direction bit i is 0.
- R5: In edge mode (sense bit = 0 at 0x404, both-edges bit = 0 at 0x408), raw status bit i (read at 0x414) sets on a rising edge of synchronised pin i when event bit i (0x40C) is 1, and on a falling edge when it is 0.
- R6: With the both-edges bit set, either edge sets the raw bit. The masked status (0x418) reads raw AND mask (0x410), and `irq` is the OR of the masked status bits.
- R7: In level mode (sense bit = 1), the raw bit sets in every cycle where the synchronised pin equals its event bit. It then stays set until cleared.
- R8: Writing 0x41C clears the raw bits written as 1, unless the event is still active in that cycle.
- R9: Writing 0x0ACCE551 to 0x520 unlocks the port, and any other value locks it. 0x520 reads 1 when locked and 0 when unlocked. The commit mask (0x524) can be written only while unlocked.
- R10: A write to the alternate-function select (0x420) changes only the bits set in the commit mask.
- R11: The pad bytes at 0x500, 0x504, 0x508, 0x50C, 0x510, 0x514, 0x518 and 0x51C are plain read/write.
- R12: Word offsets 0xFD0 to 0xFFC read the identification bytes 00,00,00,00,61,00,18,01,0D,F0,05,B1 in rising address order.
- R13: An access at an undefined offset, or at an offset with bits [1:0] not zero, reads 0 and its write is ignored.
- R14: While a response is pending and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| irq | output | 1 | Interrupt line |

## Verification
The checker assumes that the request fields stay stable while a request waits for `req_ready`. It also assumes `pin_in` is low during reset, because the edge detector starts from an all-low history. The bench changes request fields only after a transfer, drives every input one time step after a rising edge, and holds the pins at zero until the reset is released. It throttles `rsp_ready` in a fixed pattern while reading the identification bytes. This exercises response holding and request stalling without ever leaving a request half-changed.

// File: rtl/amgpio_pkg.sv
package amgpio_pkg;
  localparam int unsigned PINS = 8;
  localparam int unsigned AW   = 12;
  localparam int unsigned DW   = 32;
  localparam int unsigned WAW  = AW - 2;

  // word addresses (byte offset >> 2)
  localparam logic [WAW-1:0] W_DIR    = 10'h100;
  localparam logic [WAW-1:0] W_SENSE  = 10'h101;
  localparam logic [WAW-1:0] W_BOTH   = 10'h102;
  localparam logic [WAW-1:0] W_EVT    = 10'h103;
  localparam logic [WAW-1:0] W_MASK   = 10'h104;
  localparam logic [WAW-1:0] W_RAW    = 10'h105;
  localparam logic [WAW-1:0] W_MSTAT  = 10'h106;
  localparam logic [WAW-1:0] W_CLR    = 10'h107;
  localparam logic [WAW-1:0] W_ALT    = 10'h108;
  localparam logic [WAW-1:0] W_PAD0   = 10'h140;
  localparam int unsigned    NPAD     = 8;
  localparam logic [WAW-1:0] W_LOCK   = 10'h148;
  localparam logic [WAW-1:0] W_COMMIT = 10'h149;
  localparam logic [WAW-1:0] W_ID0    = 10'h3F4;
  localparam logic [DW-1:0]  UNLOCK_KEY = 32'h0ACC_E551;

  function automatic logic [7:0] id_byte(input logic [WAW-1:0] idx);
    case (idx)
      10'd4:   id_byte = 8'h61;
      10'd6:   id_byte = 8'h18;
      10'd7:   id_byte = 8'h01;
      10'd8:   id_byte = 8'h0D;
      10'd9:   id_byte = 8'hF0;
      10'd10:  id_byte = 8'h05;
      10'd11:  id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/amgpio_sync.sv
module amgpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/amgpio_irq.sv
module amgpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] raw_q
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    logic st_q;
    always_comb begin
      if (sense[i])     hit = (pin_s[i] == evt[i]);
      else if (both[i]) hit = pin_s[i] ^ prev_q[i];
      else if (evt[i])  hit = pin_s[i] & ~prev_q[i];
      else              hit = ~pin_s[i] & prev_q[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= hit | (st_q & ~clr_bits[i]);
    end
    assign raw_q[i] = st_q;
  end
endmodule

// File: rtl/amgpio_regs.sv
module amgpio_regs
  import amgpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] pin_s,
  input  logic [PINS-1:0] raw_q,
  output logic [DW-1:0]   rdata,
  output logic [PINS-1:0] data_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] sense_q,
  output logic [PINS-1:0] both_q,
  output logic [PINS-1:0] evt_q,
  output logic [PINS-1:0] im_q,
  output logic [PINS-1:0] clr_bits,
  output logic [PINS-1:0] afsel_q,
  output logic [PINS-1:0] commit_q,
  output logic            locked_q
);
  logic           aligned;
  logic [WAW-1:0] word;
  logic           in_data;
  logic           wr_ok;
  logic [PINS-1:0] data_d;
  logic [PINS-1:0] pad_v [NPAD];

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[AW-1:2];
  assign in_data = (word[WAW-1:WAW-2] == 2'b00);
  assign wr_ok   = wr_en && aligned;

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (!dir_q[i])                         data_d[i] = pin_s[i];
      else if (wr_ok && in_data && word[i])  data_d[i] = wdata[i];
      else                                   data_d[i] = data_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      evt_q    <= '0;
      im_q     <= '0;
      afsel_q  <= '0;
      commit_q <= '1;
      locked_q <= 1'b1;
    end else begin
      data_q <= data_d;
      if (wr_ok) begin
        case (word)
          W_DIR:    dir_q   <= wdata[PINS-1:0];
          W_SENSE:  sense_q <= wdata[PINS-1:0];
          W_BOTH:   both_q  <= wdata[PINS-1:0];
          W_EVT:    evt_q   <= wdata[PINS-1:0];
          W_MASK:   im_q    <= wdata[PINS-1:0];
          W_ALT:    afsel_q <= (afsel_q & ~commit_q) | (wdata[PINS-1:0] & commit_q);
          W_LOCK:   locked_q <= (wdata != UNLOCK_KEY);
          W_COMMIT: if (!locked_q) commit_q <= wdata[PINS-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < NPAD; k++) begin : g_pad
    logic [PINS-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   q <= '0;
      else if (wr_ok && word == W_PAD0 + WAW'(k))   q <= wdata[PINS-1:0];
    end
    assign pad_v[k] = q;
  end

  assign clr_bits = (wr_ok && word == W_CLR) ? wdata[PINS-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (in_data) begin
        rdata[PINS-1:0] = data_q & word[PINS-1:0];
      end else if (word >= W_ID0) begin
        rdata[7:0] = id_byte(word - W_ID0);
      end else if (word >= W_PAD0 && word < W_PAD0 + WAW'(NPAD)) begin
        rdata[PINS-1:0] = pad_v[word[2:0]];
      end else begin
        case (word)
          W_DIR:    rdata[PINS-1:0] = dir_q;
          W_SENSE:  rdata[PINS-1:0] = sense_q;
          W_BOTH:   rdata[PINS-1:0] = both_q;
          W_EVT:    rdata[PINS-1:0] = evt_q;
          W_MASK:   rdata[PINS-1:0] = im_q;
          W_RAW:    rdata[PINS-1:0] = raw_q;
          W_MSTAT:  rdata[PINS-1:0] = raw_q & im_q;
          W_ALT:    rdata[PINS-1:0] = afsel_q;
          W_LOCK:   rdata[0]        = locked_q;
          W_COMMIT: rdata[PINS-1:0] = commit_q;
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/amgpio_port.sv
module amgpio_port
  import amgpio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic            irq
);
  logic            accept;
  logic            wr_en;
  logic [DW-1:0]   rd_val;
  logic [PINS-1:0] pin_s, raw_q, data_q, dir_q, sense_q, both_q, evt_q, im_q;
  logic [PINS-1:0] clr_bits, afsel_q, commit_q;
  logic            locked_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  amgpio_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  amgpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(req_addr), .wdata(req_wdata),
    .pin_s(pin_s), .raw_q(raw_q), .rdata(rd_val), .data_q(data_q), .dir_q(dir_q),
    .sense_q(sense_q), .both_q(both_q), .evt_q(evt_q), .im_q(im_q),
    .clr_bits(clr_bits), .afsel_q(afsel_q), .commit_q(commit_q), .locked_q(locked_q)
  );

  amgpio_irq #(.W(PINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .sense(sense_q), .both(both_q),
    .evt(evt_q), .clr_bits(clr_bits), .raw_q(raw_q)
  );

  assign pin_out = (data_q & dir_q) | ~dir_q;
  assign irq     = |(raw_q & im_q);
endmodule

// File: rtl/amgpio_chk.sv
module amgpio_chk
  import amgpio_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic [DW-1:0]   req_wdata,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_data,
  input logic [PINS-1:0] pin_out,
  input logic            irq,
  input logic [PINS-1:0] dir_q,
  input logic [PINS-1:0] im_q,
  input logic [PINS-1:0] afsel_q,
  input logic [PINS-1:0] commit_q,
  input logic            locked_q
);
  logic lock_wr;
  assign lock_wr = req_valid && req_ready && req_write && (req_addr == {W_LOCK, 2'b00});

  // R14
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R14
  req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R9
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && (req_wdata != UNLOCK_KEY) |=> locked_q);
  // R9
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr && (req_wdata == UNLOCK_KEY) |=> !locked_q);
  // R9
  commit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(commit_q));
  // R10
  afsel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((afsel_q ^ $past(afsel_q)) & ~$past(commit_q)) == '0);
  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (im_q == '0) |-> !irq);
  // R4
  input_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q) & ~pin_out) == '0);
endmodule

bind amgpio_port amgpio_chk u_chk (.*);

// File: tb/sim_amgpio_port.sv
`timescale 1ns/100ps
module sim_amgpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_data;
  logic [7:0]  pin_in = '0, pin_out;

  int checks = 0, errors = 0;
  bit done = 1'b0, bp = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  amgpio_port u0 (.*);

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (1) begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    xfer(1'b1, a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    xfer(1'b0, a, 32'h0);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic pins(input logic [7:0] v);
    @(posedge clk); #1; pin_in = v;
    repeat (5) @(posedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !rsp_ready) chk("R14 stall", {31'b0, req_ready}, 32'h0);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk("R14 unexpected response", rsp_data, 32'hxxxx_xxxx);
      else chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
    end
  end

  // response back-pressure pattern
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      rsp_ready = bp ? (n % 3 == 0) : 1'b1;
    end
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 pin_out", {24'b0, pin_out}, 32'hFF);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(12'h520, 1, "R1 lock");
    rd(12'h524, 32'hFF, "R1 commit");
    rd(12'h400, 0, "R1 dir");
    rd(12'h420, 0, "R1 afsel");

    // R2 / R4 masked data access
    wr(12'h400, 32'hF0);
    wr(12'h3FC, 32'hA5);
    @(negedge clk); chk("R4 pin_out after full write", {24'b0, pin_out}, 32'hAF);
    wr(12'h0C0, 32'h00);
    @(negedge clk); chk("R2 masked write", {24'b0, pin_out}, 32'h8F);
    rd(12'h300, 32'h80, "R2 masked read");
    pins(8'h05);
    rd(12'h3FC, 32'h85, "R3 input bits");
    rd(12'h004, 32'h01, "R2 single bit read");
    // R3 writes to input bits ignored
    wr(12'h3FC, 32'h0F);
    rd(12'h3FC, 32'h05, "R3 write ignored on inputs");
    @(negedge clk); chk("R4 pin_out", {24'b0, pin_out}, 32'h0F);

    // R5 rising edge
    wr(12'h41C, 32'hFF);
    wr(12'h40C, 32'h02);
    wr(12'h410, 32'h02);
    pins(8'h07);
    @(negedge clk); chk("R5 irq rising", {31'b0, irq}, 1);
    rd(12'h414, 32'h02, "R5 raw rising");
    rd(12'h418, 32'h02, "R6 masked");
    wr(12'h41C, 32'h02);
    @(negedge clk); chk("R8 irq after clear", {31'b0, irq}, 0);
    rd(12'h414, 32'h00, "R8 raw cleared");
    // R5 falling edge
    wr(12'h40C, 32'h00);
    pins(8'h05);
    rd(12'h414, 32'h02, "R5 raw falling");
    @(negedge clk); chk("R5 irq falling", {31'b0, irq}, 1);
    wr(12'h41C, 32'hFF);
    // R6 both edges
    wr(12'h408, 32'h04);
    pins(8'h01);
    rd(12'h414, 32'h04, "R6 both fall");
    wr(12'h41C, 32'hFF);
    pins(8'h05);
    rd(12'h414, 32'h04, "R6 both rise");
    rd(12'h418, 32'h00, "R6 masked off");
    @(negedge clk); chk("R6 irq masked", {31'b0, irq}, 0);
    wr(12'h41C, 32'hFF);
    // R7 level high
    wr(12'h40C, 32'h08);
    wr(12'h404, 32'h08);
    rd(12'h414, 32'h00, "R7 level inactive");
    pins(8'h0D);
    rd(12'h414, 32'h08, "R7 level active");
    wr(12'h41C, 32'h08);
    rd(12'h414, 32'h08, "R8 clear while active");
    pins(8'h05);
    rd(12'h414, 32'h08, "R7 sticky");
    wr(12'h41C, 32'h08);
    rd(12'h414, 32'h00, "R8 clear after release");

    // R9 / R10 lock, commit, alternate function
    wr(12'h420, 32'h3C);
    rd(12'h420, 32'h3C, "R10 afsel full commit");
    wr(12'h524, 32'h0F);
    rd(12'h524, 32'hFF, "R9 commit locked");
    wr(12'h520, 32'h0ACCE551);
    rd(12'h520, 0, "R9 unlocked");
    wr(12'h524, 32'h0F);
    rd(12'h524, 32'h0F, "R9 commit unlocked");
    wr(12'h520, 32'h00012345);
    rd(12'h520, 1, "R9 relocked");
    wr(12'h420, 32'hC3);
    rd(12'h420, 32'h33, "R10 afsel partial");
    wr(12'h524, 32'h00);
    rd(12'h524, 32'h0F, "R9 commit frozen");

    // R11 pad registers
    for (int k = 0; k < 8; k++) wr(12'h500 + 12'(k * 4), 32'h11 * (k + 1));
    for (int k = 0; k < 8; k++) rd(12'h500 + 12'(k * 4), (32'h11 * (k + 1)) & 32'hFF, "R11 pad");

    // R12 id bytes under R14 back-pressure
    drain();
    bp = 1'b1;
    begin
      logic [7:0] idv [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                               8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
      for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(k * 4), {24'b0, idv[k]}, "R12 id");
    end
    drain();
    bp = 1'b0;

    // R13 undefined and unaligned
    rd(12'h424, 0, "R13 hole read");
    rd(12'h41C, 0, "R13 clear reads zero");
    rd(12'h402, 0, "R13 unaligned read");
    wr(12'h800, 32'hFF);
    wr(12'h401, 32'h00);
    rd(12'h400, 32'hF0, "R13 writes ignored");
    drain();
    repeat (2) @(posedge clk);
    report();
  end
endmodule